// File: doc/BRIEF.md
# Four-bit Status Code Register

This block holds the four status flags that form the top nibble (bits 0 through 3, MSB-first numbering) of the processor status word. Here it is used only as a plain register. Each class of operation that writes it has its own enable and its own 4-bit source. The sources are the operator sense switches, the trap accumulator, the top nibble of the result bus, and a mid-word nibble of the result bus (bits 24 to 27). A clear enable forces the flags to zero.

Several enables can be active in the same cycle. A fixed priority decides which one takes effect. When no enable is active, the register keeps its value. Setting flags from arithmetic results is handled elsewhere and does not pass through this block.

Top module: `stat_code_reg`

## Requirements
- R1: A synchronous active-high reset sets the flags output to 4'b0000 on the next rising edge.
- R2: With no enable active, the flags output keeps its value across clock edges.
- R3: When the clear enable is active, the flags become 4'b0000 on the next edge, regardless of the other enables.
- R4: When the trap-capture enable is active and clear is not, the flags take the trap accumulator value on the next edge, with bit i of the input going to bit i of the output.
- R5: When the switch-capture enable is active and neither clear nor trap is active, the flags take the sense-switch vector.
- R6: When the high-nibble load enable is the highest active enable, the flags take result-bus bits 0 to 3. Bus bit 0 is the MSB of the 32-bit word (`res_bus[31]`) and goes to flag 1, which is output bit 3.
- R7: When the mid-nibble load enable is the only active enable, the flags take result-bus bits 24 to 27. These are `res_bus[7:4]` in LSB-first indexing. Bus bit 24 (`res_bus[7]`) goes to flag 1 (output bit 3), and bus bit 27 (`res_bus[4]`) goes to flag 4 (output bit 0).
- R8: The priority order, highest first, is clear, trap, switches, high nibble, mid nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_en | input | 1 | Clear the flags |
| trap_en | input | 1 | Capture the trap accumulator |
| trap_acc | input | 4 | Trap accumulator value |
| sw_en | input | 1 | Capture the sense switches |
| sense_sw | input | 4 | Sense switch states |
| hi_en | input | 1 | Load result-bus bits 0 to 3 |
| mid_en | input | 1 | Load result-bus bits 24 to 27 |
| res_bus | input | 32 | Result bus, `res_bus[31]` is bus bit 0 |
| flags | output | 4 | Flags; `flags[3]` is flag 1 (word bit 0) |

## Verification
A wrong selection or a miswired nibble shows up on `flags` at the first edge after the offending enable pattern, since the block has a single register stage. The bench uses distinct patterns on every source at the same time, so that taking the wrong source cannot produce the expected value by chance. A reversed nibble is caught because the test values are asymmetric. A hold fault shows up one edge after all enables drop.

// File: rtl/stat_code_pkg.sv
package stat_code_pkg;
    localparam int FLAG_W = 4;
    localparam int BUS_W  = 32;
    localparam int MID_LO = BUS_W - 1 - 27;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_CLR,
        SRC_TRAP,
        SRC_SW,
        SRC_HI,
        SRC_MID
    } src_sel_e;

    typedef struct packed {
        logic clr;
        logic trap;
        logic sw;
        logic hi;
        logic mid;
    } load_req_t;

    function automatic flags_t hi_nibble(input logic [BUS_W-1:0] b);
        return b[BUS_W-1 -: FLAG_W];
    endfunction

    function automatic flags_t mid_nibble(input logic [BUS_W-1:0] b);
        return b[MID_LO +: FLAG_W];
    endfunction
endpackage

// File: rtl/stat_code_arb.sv
module stat_code_arb
    import stat_code_pkg::*;
(
    input  load_req_t req,
    output src_sel_e  sel
);
    always_comb begin
        if (req.clr)       sel = SRC_CLR;
        else if (req.trap) sel = SRC_TRAP;
        else if (req.sw)   sel = SRC_SW;
        else if (req.hi)   sel = SRC_HI;
        else if (req.mid)  sel = SRC_MID;
        else               sel = SRC_HOLD;
    end
endmodule

// File: rtl/stat_code_mux.sv
module stat_code_mux
    import stat_code_pkg::*;
(
    input  src_sel_e         sel,
    input  flags_t           cur,
    input  flags_t           trap_acc,
    input  flags_t           sense_sw,
    input  logic [BUS_W-1:0] res_bus,
    output flags_t           nxt
);
    always_comb begin
        unique case (sel)
            SRC_CLR:  nxt = '0;
            SRC_TRAP: nxt = trap_acc;
            SRC_SW:   nxt = sense_sw;
            SRC_HI:   nxt = hi_nibble(res_bus);
            SRC_MID:  nxt = mid_nibble(res_bus);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/stat_code_reg.sv
module stat_code_reg
    import stat_code_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic              trap_en,
    input  logic [3:0]        trap_acc,
    input  logic              sw_en,
    input  logic [3:0]        sense_sw,
    input  logic              hi_en,
    input  logic              mid_en,
    input  logic [31:0]       res_bus,
    output logic [3:0]        flags
);
    load_req_t req;
    src_sel_e  sel;
    flags_t    nxt;
    flags_t    q;

    assign req = '{clr: clr_en, trap: trap_en, sw: sw_en, hi: hi_en, mid: mid_en};

    stat_code_arb u_arb (.req(req), .sel(sel));

    stat_code_mux u_mux (
        .sel(sel), .cur(q), .trap_acc(trap_acc), .sense_sw(sense_sw),
        .res_bus(res_bus), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign flags = q;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> flags == 4'b0);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(clr_en || trap_en || sw_en || hi_en || mid_en) |=> $stable(flags));
    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> flags == 4'b0);
    // R4
    trap_load_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_en && !clr_en) |=> flags == $past(trap_acc));
    // R5
    sw_load_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !trap_en && !clr_en) |=> flags == $past(sense_sw));
    // R6
    hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_en && !sw_en && !trap_en && !clr_en) |=> flags == $past(res_bus[31:28]));
    // R7
    mid_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mid_en && !hi_en && !sw_en && !trap_en && !clr_en) |=> flags == $past(res_bus[7:4]));
endmodule

// File: tb/tb_stat_code_reg.sv
module tb_stat_code_reg;
    logic clk = 0, rst = 1;
    logic clr_en = 0, trap_en = 0, sw_en = 0, hi_en = 0, mid_en = 0;
    logic [3:0] trap_acc = 0, sense_sw = 0;
    logic [31:0] res_bus = 0;
    logic [3:0] flags;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stat_code_reg dut (.*);

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (flags !== exp) begin
            fails++;
            $display("FAIL %s: flags=%b expected=%b", req, flags, exp);
        end
    endtask

    task automatic step(input logic c, t, s, h, m);
        @(negedge clk);
        clr_en = c; trap_en = t; sw_en = s; hi_en = h; mid_en = m;
        @(negedge clk);
        clr_en = 0; trap_en = 0; sw_en = 0; hi_en = 0; mid_en = 0;
    endtask

    task automatic set_src(input logic [3:0] ta, input logic [3:0] ss, input logic [31:0] rb);
        trap_acc = ta; sense_sw = ss; res_bus = rb;
    endtask

    task automatic t_reset();
        set_src(4'hF, 4'hF, 32'hFFFF_FFFF);
        step(0, 1, 0, 0, 0);
        rst = 1; @(negedge clk); rst = 0;
        check("R1", 4'b0000);
    endtask

    task automatic t_trap();
        set_src(4'b1011, 4'b0110, 32'h5000_00C0);
        step(1, 1, 1, 1, 1); check("R3", 4'b0000);
        step(0, 1, 1, 1, 1); check("R4", 4'b1011);
        step(0, 1, 0, 0, 0); check("R4", 4'b1011);
    endtask

    task automatic t_sw();
        set_src(4'b0001, 4'b0110, 32'h9000_0030);
        step(0, 0, 1, 1, 1); check("R5", 4'b0110);
        set_src(4'b0001, 4'b1110, 32'h9000_0030);
        step(0, 0, 1, 0, 0); check("R5", 4'b1110);
    endtask

    task automatic t_hi();
        // bus bits 0..3 = res_bus[31:28] = 1001 -> flags 1001
        set_src(4'b0001, 4'b0010, 32'h9000_00C0);
        step(0, 0, 0, 1, 1); check("R6 R8", 4'b1001);
        set_src(4'b0001, 4'b0010, 32'h1FFF_FFFF);
        step(0, 0, 0, 1, 0); check("R6", 4'b0001);
    endtask

    task automatic t_mid();
        // bus bits 24..27 = res_bus[7:4]; bit 24 (res_bus[7]) -> flags[3]
        set_src(4'b0000, 4'b0000, 32'hF000_0080);
        step(0, 0, 0, 0, 1); check("R7", 4'b1000);
        set_src(4'b0000, 4'b0000, 32'h0FFF_FF3F);
        step(0, 0, 0, 0, 1); check("R7", 4'b0011);
    endtask

    task automatic t_hold();
        set_src(4'hA, 4'h5, 32'hFFFF_FFFF);
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R2", 4'b0011);
        step(1, 0, 0, 0, 0); check("R3", 4'b0000);
        @(negedge clk); check("R2", 4'b0000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        t_reset();
        t_trap();
        t_sw();
        t_hi();
        t_mid();
        t_hold();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule